// File: doc/BRIEF.md
# Paired Transition Firing Sequencer with Fair Arbitration

This block sequences two neighbouring transitions of a safe token net built in hardware. Each transition watches two summary lines from its input places. One says every input place holds a token. The other says every input place is empty. The transition drives one active-low fire line. A falling fire line tells the input places to give up their tokens. A rising fire line tells the output places to take a token each. The output places are assumed empty whenever the inputs fill, so no output check is made.

Firing is a two-phase handshake. Once the fire line is low, it stays low until the all-empty line reports that every input has drained. The all-full line dropping is not enough, because it falls as soon as the first input empties. This keeps a transition from being re-enabled early by places that empty at different speeds.

The two transitions may compete for one shared token, so a clocked arbiter lets only one of them fire at a time. It holds the other back until the winner's fire line is high again. When both ask in the same cycle, a round-robin bit decides, so neither side is favoured. Per-transition outputs give a firing indicator and a sticky protocol-error flag.

Top module: `transition_pair_seq`

## Requirements
- R1: While rstN is low and in the first cycle after it is released, fireN is 2'b11, firing is 2'b00 and seqErr is 2'b00.
- R2: fireN[i] goes low only on the clock edge after one at which allFull[i] was sampled high while both fireN bits were high.
- R3: Once fireN[i] is low, it stays low on every edge at which allEmpty[i] is sampled low, even after allFull[i] has fallen.
- R4: When allEmpty[i] is sampled high while fireN[i] is low, fireN[i] is high after that edge.
- R5: At most one fireN bit is low at any time. A transition that requests while the other is firing is held until the other's fireN is back high, and it fires on the edge after that.
- R6: When both allFull bits are sampled high while both fireN bits are high, a round-robin bit picks the winner and then flips. After reset the bit favours transition 0. A grant to a single requester leaves the bit unchanged.
- R7: firing[i] is high exactly in the cycles in which fireN[i] is low.
- R8: If allEmpty[i] is sampled rising (low at one edge, high at the next) while fireN[i] is high, seqErr[i] goes high after that edge and stays high until reset. A rise of allEmpty[i] while fireN[i] is low does not set it. Bit i of every two-bit port belongs to transition i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allFull | input | 2 | Per transition: every input place holds a token |
| allEmpty | input | 2 | Per transition: every input place is empty |
| fireN | output | 2 | Per transition active-low fire line: falling empties the inputs, rising fills the outputs |
| firing | output | 2 | Per transition: high while its fire line is low |
| seqErr | output | 2 | Per transition sticky flag: inputs drained without a firing |

## Verification
A fire line falls one edge after the edge that samples an uncontested or winning request. It rises one edge after the edge that samples allEmpty high. A held-back transition fires two edges after the edge that sampled the winner's drain: one edge to release the winner, one to grant the loser. The error flag appears one edge after the rise of allEmpty. The bench changes inputs 1 ns after a rising edge and reads outputs 1 ns after a later rising edge, counting edges to the cycle in which each result is due. It also checks that results do not appear early, for example that both fire lines are high in the cycle between one release and the next grant.

// File: rtl/tps_pkg.sv
`timescale 1ns/1ps
package tps_pkg;
  localparam int PAIR_W = 2;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FIRE = 1'b1
  } tranState_t;

  typedef struct packed {
    logic [PAIR_W-1:0] grant;
  } seqStrobe_t;
endpackage

// File: rtl/tps_arbiter.sv
`timescale 1ns/1ps
module tps_arbiter
  import tps_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [PAIR_W-1:0] allFull,
  input  logic [PAIR_W-1:0] fireN,
  output seqStrobe_t        strobe
);
  logic              rrPtr;
  logic              pairIdle;
  logic [PAIR_W-1:0] req;
  logic              contested;

  assign pairIdle  = &fireN;
  assign req       = allFull & {PAIR_W{pairIdle}};
  assign contested = &req;

  always_comb begin
    strobe.grant = req;
    if (contested) begin
      strobe.grant = rrPtr ? 2'b10 : 2'b01;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= 1'b0;
    end else if (contested) begin
      rrPtr <= ~rrPtr;
    end
  end

  // R5: no grant while either transition is firing
  p_block_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    (fireN != 2'b11) |-> (strobe.grant == '0));

  // R6: a contested grant goes to one side only
  p_single_grant_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.grant));

  // R5: the pair never fires together
  p_mutex_r5: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~fireN) <= 1);
endmodule

// File: rtl/tps_datapath.sv
`timescale 1ns/1ps
module tps_datapath
  import tps_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [PAIR_W-1:0] allFull,
  input  logic [PAIR_W-1:0] allEmpty,
  output logic [PAIR_W-1:0] fireN,
  output logic [PAIR_W-1:0] firing,
  output logic [PAIR_W-1:0] seqErr
);
  for (genvar g = 0; g < PAIR_W; g++) begin : gTran
    tranState_t state;
    logic       emptyPrev;
    logic       errFlag;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        state     <= ST_IDLE;
        emptyPrev <= 1'b1;
        errFlag   <= 1'b0;
      end else begin
        emptyPrev <= allEmpty[g];
        if (state == ST_IDLE && allEmpty[g] && !emptyPrev) begin
          errFlag <= 1'b1;
        end
        case (state)
          ST_IDLE: if (strobe.grant[g]) state <= ST_FIRE;
          ST_FIRE: if (allEmpty[g])     state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end

    assign fireN[g]  = (state != ST_FIRE);
    assign firing[g] = (state == ST_FIRE);
    assign seqErr[g] = errFlag;

    // R2: a falling fire line follows a full-input sample
    p_fire_needs_full_r2: assert property (@(posedge clk) disable iff (!rstN)
      $fell(fireN[g]) |-> $past(allFull[g]));

    // R3: hold low until every input has drained
    p_hold_until_empty_r3: assert property (@(posedge clk) disable iff (!rstN)
      (!fireN[g] && !allEmpty[g]) |=> !fireN[g]);

    // R4: release after the drain is seen
    p_release_on_empty_r4: assert property (@(posedge clk) disable iff (!rstN)
      (!fireN[g] && allEmpty[g]) |=> fireN[g]);

    // R8: the error flag is sticky
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
      seqErr[g] |=> seqErr[g]);
  end
endmodule

// File: rtl/transition_pair_seq.sv
`timescale 1ns/1ps
module transition_pair_seq
  import tps_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] allFull,
  input  logic [1:0] allEmpty,
  output logic [1:0] fireN,
  output logic [1:0] firing,
  output logic [1:0] seqErr
);
  seqStrobe_t strobe;

  tps_arbiter uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .allFull (allFull),
    .fireN   (fireN),
    .strobe  (strobe)
  );

  tps_datapath uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .allFull  (allFull),
    .allEmpty (allEmpty),
    .fireN    (fireN),
    .firing   (firing),
    .seqErr   (seqErr)
  );
endmodule

// File: tb/tb_transition_pair_seq.sv
`timescale 1ns/1ps
module tb_transition_pair_seq;
  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] allFull;
  logic [1:0] allEmpty;
  logic [1:0] fireN;
  logic [1:0] firing;
  logic [1:0] seqErr;
  int testCount = 0;
  int failCount = 0;

  always #5 clk = ~clk;

  transition_pair_seq dut (
    .clk(clk), .rstN(rstN), .allFull(allFull), .allEmpty(allEmpty),
    .fireN(fireN), .firing(firing), .seqErr(seqErr)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Both transitions request together; the winner is named by the caller.
  task automatic contest(input int winner, input string tag);
    int loser = 1 - winner;
    logic [1:0] winLow = (winner == 0) ? 2'b10 : 2'b01;
    logic [1:0] loseLow = (winner == 0) ? 2'b01 : 2'b10;
    allFull = 2'b11; allEmpty = 2'b00;
    tick();
    check({tag, " R6 contested winner"}, fireN, winLow);
    tick(3);
    check({tag, " R5 loser held"}, fireN, winLow);
    allFull[winner] = 1'b0; allEmpty[winner] = 1'b1;
    tick();
    check({tag, " R5 gap after release"}, fireN, 2'b11);
    tick();
    check({tag, " R5 loser fires next"}, fireN, loseLow);
    allFull[loser] = 1'b0; allEmpty[loser] = 1'b1;
    tick();
    check({tag, " R4 loser released"}, fireN, 2'b11);
  endtask

  task automatic test_reset();
    rstN = 1'b0; allFull = 2'b00; allEmpty = 2'b11;
    tick(3);
    check("R1 fireN in reset", fireN, 2'b11);
    check("R1 firing in reset", firing, 2'b00);
    check("R1 seqErr in reset", seqErr, 2'b00);
    rstN = 1'b1;
    tick();
    check("R1 fireN after release", fireN, 2'b11);
  endtask

  task automatic test_single_fire();
    allFull[0] = 1'b1; allEmpty[0] = 1'b0;
    tick();
    check("R2 fire on full", fireN, 2'b10);
    check("R7 indicator while firing", firing, 2'b01);
    allFull[0] = 1'b0;
    tick(3);
    check("R3 held after full drops", fireN, 2'b10);
    allEmpty[0] = 1'b1;
    tick();
    check("R4 release on empty", fireN, 2'b11);
    check("R7 indicator idle", firing, 2'b00);
    check("R8 no error on normal drain", seqErr, 2'b00);
  endtask

  task automatic test_no_fire_without_full();
    allEmpty[1] = 1'b0;
    tick(3);
    check("R2 no fire while not full", fireN, 2'b11);
    allFull[1] = 1'b1;
    tick();
    check("R2 single transition 1 fires", fireN, 2'b01);
    allFull[1] = 1'b0; allEmpty[1] = 1'b1;
    tick();
    check("R4 transition 1 released", fireN, 2'b11);
  endtask

  task automatic test_error();
    allEmpty[1] = 1'b0;
    tick(2);
    check("R8 no error before rise", seqErr, 2'b00);
    allEmpty[1] = 1'b1;
    tick();
    check("R8 error on unfired drain", seqErr, 2'b10);
    tick(4);
    check("R8 error sticky", seqErr, 2'b10);
    check("R8 fire lines untouched", fireN, 2'b11);
  endtask

  initial begin
    #2000000;
    failCount++; testCount++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    test_reset();
    test_single_fire();
    test_no_fire_without_full();
    contest(0, "first");
    contest(1, "second");
    test_no_fire_without_full();
    contest(0, "third after uncontested");
    test_error();
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule